// File: doc/BRIEF.md
# Four-Lane Interleaved Serial Backplane Output

The block merges the receive side of four framer lanes onto a single high-speed serial wire. Every frame carries, in order, one framing bit from each lane, then a fixed number of 8-bit payload time slots from each lane, then a 4-bit signaling nibble (A, B, C, D) from each lane. Frames follow each other back to back on a free-running serial clock of 12.352 MHz or 16.384 MHz. A frame sync input of programmable polarity restarts the frame at any time.

Two orderings are offered. In byte-interleaved ordering one lane's whole field goes out before the next lane's, one bit per clock. In bit-interleaved ordering bit k of lanes 0, 1, 2 and 3 go out before bit k+1 of any lane, each bit lasting two clocks. The first four bits of each payload slot are then shaped return-to-zero: driven for the first clock, forced low for the second. All output changes are launched from the rising clock edge, so a downstream receiver can sample on the falling edge.

Each lane hands over one payload byte per time slot through a valid/ready pair, and gives its framing bit and signaling nibble as levels sampled at each frame start. A lane that has no byte ready when its slot is loaded is sent as all ones, and its sticky underrun flag is set. A sequencer with the states IDLE, FRAMING, PAYLOAD and SIGNALING drives the block: a sync edge moves any state to FRAMING; FRAMING moves to PAYLOAD after the last lane's framing bit; PAYLOAD stays in PAYLOAD from one slot to the next and moves to SIGNALING after the last slot; SIGNALING moves to FRAMING after the last nibble bit. IDLE is left only by a sync edge.

Top module: `tdm_bitmux_out`

## Requirements
- R1: While reset is held and after it until the first sync edge, `ser_out` is 1, `ch_ready` is 0 and `underrun` is 0; reset clears every underrun flag.
- R2: With `sync_act_high` = 1 the sync is active when `sync_in` is 1, with 0 when it is 0. Only the change from inactive to active restarts the frame; holding sync active does not restart it again.
- R3: The rising edge that first sees sync active loads the framing bits, signaling and ordering mode; the framing bit of lane 0 is on `ser_out` from the next rising edge onward, followed by lanes 1, 2, 3. Frames of NCH*(1+NSLOT*8+4) bit periods repeat without gaps.
- R4: In byte ordering (`bit_mode` = 0 at frame start) each bit lasts one clock; each payload slot sends lane 0's byte from bit 7 down to bit 0, then lanes 1, 2, 3; the signaling field sends lane 0's nibble then lanes 1 to 3, A first, where A is bit 4c+3 of `ch_sig` for lane c and D is bit 4c.
- R5: In bit ordering (`bit_mode` = 1 at frame start) each bit lasts two clocks and bit k of lanes 0, 1, 2, 3 precede bit k+1, in payload (bit 7 first) and in signaling (A first).
- R6: In bit ordering, the first four payload bits of each slot (bits 7 to 4) are driven in their first clock and 0 in their second; framing, signaling and payload bits 3 to 0 hold both clocks.
- R7: `ch_ready` is high on all lanes for exactly the one clock before each payload slot starts; the byte on `ch_data[8c+7:8c]` is taken at the closing edge of that clock when `ch_valid[c]` is 1.
- R8: A lane whose `ch_valid` is 0 during its ready clock sends 8'hFF in that slot and raises `underrun[c]`, which stays high until reset.
- R9: A sync edge in mid-frame abandons the current frame and starts a new one exactly as in R3.
- R10: Changing `bit_mode` during a frame has no effect before the next frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_in | input | 1 | Frame sync |
| sync_act_high | input | 1 | Sync polarity: 1 active high, 0 active low |
| bit_mode | input | 1 | 1 bit-interleaved with return-to-zero, 0 byte-interleaved |
| ch_valid | input | NCH | Per-lane payload byte valid |
| ch_data | input | NCH*8 | Per-lane payload byte, lane c at bits 8c+7:8c |
| ch_fbit | input | NCH | Per-lane framing bit |
| ch_sig | input | NCH*4 | Per-lane signaling nibble, A at bit 4c+3 |
| ch_ready | output | NCH | Byte take strobe, one clock before each slot |
| ser_out | output | 1 | Multiplexed serial output |
| underrun | output | NCH | Sticky per-lane underrun flags |

## Verification
A wrong bit, lane or slot counter shifts every later bit of the frame, so the bench rebuilds the expected stream from the bytes it saw taken and compares each clock; a counter slip appears on `ser_out` at the first bit after it and repeats until the next sync. A wrong half-period phase shows as return-to-zero lows in the wrong clock within two clocks, and a wrong load instant shows on `ch_ready` one clock ahead of the slot. An underrun flag that fails to stick is seen when the flags are read after each frame.

// File: rtl/tdm_mux_pkg.sv
package tdm_mux_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_FRM  = 2'd1,
        PH_PAY  = 2'd2,
        PH_SIG  = 2'd3
    } phase_t;
endpackage

// File: rtl/tdm_sync_det.sv
module tdm_sync_det (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_in,
    input  logic act_high,
    output logic sync_edge
);
    logic act;
    logic act_q;

    assign act = act_high ? sync_in : ~sync_in;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) act_q <= 1'b0;
        else        act_q <= act;
    end

    assign sync_edge = act & ~act_q;

    // R2: a held sync level yields one restart only
    a_r2_single_edge: assert property (@(posedge clk) disable iff (!rst_n)
        sync_edge |=> !sync_edge);
endmodule

// File: rtl/tdm_seq.sv
module tdm_seq
    import tdm_mux_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int NSLOT  = 24,
    parameter int BYTE_W = 8,
    parameter int SIG_W  = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sync_edge,
    input  logic                 bit_mode_in,
    output phase_t               phase_o,
    output logic [$clog2(NCH)-1:0]    ch_o,
    output logic [$clog2(BYTE_W)-1:0] bit_o,
    output logic                 half_o,
    output logic                 mode_o,
    output logic                 slot_load_o,
    output logic                 frame_load_o
);
    localparam int CH_W   = $clog2(NCH);
    localparam int BIT_W  = $clog2(BYTE_W);
    localparam int SLOT_W = $clog2(NSLOT);

    phase_t              phase_q, phase_n;
    logic [CH_W-1:0]     ch_q, ch_n;
    logic [BIT_W-1:0]    bit_q, bit_n;
    logic [SLOT_W-1:0]   slot_q, slot_n;
    logic                half_q, half_n;
    logic                mode_q, mode_n;

    logic [BIT_W-1:0]    last_idx;
    logic                step, last_bit, last_ch, last_slot, phase_done;

    // field width of the current phase
    always_comb begin
        unique case (phase_q)
            PH_PAY:  last_idx = BIT_W'(BYTE_W - 1);
            PH_SIG:  last_idx = BIT_W'(SIG_W - 1);
            default: last_idx = '0;
        endcase
    end

    assign step       = (phase_q != PH_IDLE) && (!mode_q || half_q);
    assign last_bit   = (bit_q == last_idx);
    assign last_ch    = (ch_q == CH_W'(NCH - 1));
    assign last_slot  = (slot_q == SLOT_W'(NSLOT - 1));
    assign phase_done = step && last_bit && last_ch;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            ch_q    <= '0;
            bit_q   <= '0;
            slot_q  <= '0;
            half_q  <= 1'b0;
            mode_q  <= 1'b0;
        end else begin
            phase_q <= phase_n;
            ch_q    <= ch_n;
            bit_q   <= bit_n;
            slot_q  <= slot_n;
            half_q  <= half_n;
            mode_q  <= mode_n;
        end
    end

    // next state
    always_comb begin
        phase_n = phase_q;
        ch_n    = ch_q;
        bit_n   = bit_q;
        slot_n  = slot_q;
        half_n  = half_q;
        mode_n  = mode_q;
        if (sync_edge) begin
            phase_n = PH_FRM;
            ch_n    = '0;
            bit_n   = '0;
            slot_n  = '0;
            half_n  = 1'b0;
            mode_n  = bit_mode_in;
        end else begin
            unique case (phase_q)
                PH_IDLE: begin
                end
                default: begin
                    if (mode_q) half_n = ~half_q;
                    if (step) begin
                        if (mode_q) begin
                            ch_n = last_ch ? '0 : ch_q + 1'b1;
                            if (last_ch) bit_n = last_bit ? '0 : bit_q + 1'b1;
                        end else begin
                            bit_n = last_bit ? '0 : bit_q + 1'b1;
                            if (last_bit) ch_n = last_ch ? '0 : ch_q + 1'b1;
                        end
                    end
                    if (phase_done) begin
                        ch_n  = '0;
                        bit_n = '0;
                        unique case (phase_q)
                            PH_FRM: begin
                                phase_n = PH_PAY;
                                slot_n  = '0;
                            end
                            PH_PAY: begin
                                if (last_slot) phase_n = PH_SIG;
                                else           slot_n  = slot_q + 1'b1;
                            end
                            PH_SIG: begin
                                phase_n = PH_FRM;
                                half_n  = 1'b0;
                                mode_n  = bit_mode_in;
                            end
                            default: begin
                            end
                        endcase
                    end
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        phase_o      = phase_q;
        ch_o         = ch_q;
        bit_o        = bit_q;
        half_o       = half_q;
        mode_o       = mode_q;
        slot_load_o  = !sync_edge && phase_done &&
                       (phase_q == PH_FRM || (phase_q == PH_PAY && !last_slot));
        frame_load_o = sync_edge || (phase_done && phase_q == PH_SIG);
    end

    // R9: any sync edge restarts at lane 0 framing bit
    a_r9_sync_restart: assert property (@(posedge clk) disable iff (!rst_n)
        sync_edge |=> (phase_q == PH_FRM && ch_q == '0 && bit_q == '0 && !half_q));
    // R7: a byte load lands on the first position of a payload slot
    a_r7_load_at_slot: assert property (@(posedge clk) disable iff (!rst_n)
        slot_load_o |=> (phase_q == PH_PAY && ch_q == '0 && bit_q == '0 && !half_q));
    // R3: signaling is always followed by a new framing field
    a_r3_wrap_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_SIG && phase_done && !sync_edge) |=> phase_q == PH_FRM);
    // R5: in bit ordering every bit spans two clocks
    a_r5_half_alternates: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q && phase_q != PH_IDLE && !sync_edge) |=> half_q != $past(half_q));
endmodule

// File: rtl/tdm_lane.sv
module tdm_lane
    import tdm_mux_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int SIG_W  = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      slot_load,
    input  logic                      frame_load,
    input  logic                      valid_i,
    input  logic [BYTE_W-1:0]         data_i,
    input  logic                      fbit_i,
    input  logic [SIG_W-1:0]          sig_i,
    input  phase_t                    phase_i,
    input  logic [$clog2(BYTE_W)-1:0] bit_i,
    output logic                      bit_o,
    output logic                      underrun_o
);
    logic [BYTE_W-1:0] byte_q;
    logic              fbit_q;
    logic [SIG_W-1:0]  sig_q;
    logic              underrun_q;
    int                sel;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byte_q     <= '1;
            fbit_q     <= 1'b1;
            sig_q      <= '1;
            underrun_q <= 1'b0;
        end else begin
            if (slot_load) begin
                byte_q <= valid_i ? data_i : '1;
                if (!valid_i) underrun_q <= 1'b1;
            end
            if (frame_load) begin
                fbit_q <= fbit_i;
                sig_q  <= sig_i;
            end
        end
    end

    always_comb begin
        sel = int'(bit_i);
        unique case (phase_i)
            PH_FRM:  bit_o = fbit_q;
            PH_PAY:  bit_o = byte_q[BYTE_W - 1 - sel];
            PH_SIG:  bit_o = (sel < SIG_W) ? sig_q[SIG_W - 1 - sel] : 1'b1;
            default: bit_o = 1'b1;
        endcase
    end

    assign underrun_o = underrun_q;

    // R8: underrun flag never clears without reset
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        underrun_q |=> underrun_q);
    // R8: a missing byte is replaced by all ones
    a_r8_fill_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_load && !valid_i) |=> (byte_q == '1 && underrun_q));
endmodule

// File: rtl/tdm_shaper.sv
module tdm_shaper
    import tdm_mux_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int BYTE_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NCH-1:0]            lane_bits,
    input  logic [$clog2(NCH)-1:0]    ch_i,
    input  phase_t                    phase_i,
    input  logic [$clog2(BYTE_W)-1:0] bit_i,
    input  logic                      half_i,
    input  logic                      mode_i,
    output logic                      ser_o
);
    localparam int BIT_W = $clog2(BYTE_W);
    localparam int RZ_N  = BYTE_W / 2;

    logic rtz;
    logic ser_d;
    logic ser_q;

    assign rtz   = mode_i && phase_i == PH_PAY && half_i && (bit_i < BIT_W'(RZ_N));
    assign ser_d = rtz ? 1'b0 : lane_bits[ch_i];

    // launch register: output only moves on the rising edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ser_q <= 1'b1;
        else        ser_q <= ser_d;
    end

    assign ser_o = ser_q;

    // R1: idle line is marking
    a_r1_idle_mark: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_i == PH_IDLE) |=> ser_q);
endmodule

// File: rtl/tdm_bitmux_out.sv
module tdm_bitmux_out
    import tdm_mux_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int NSLOT  = 24,
    parameter int BYTE_W = 8,
    parameter int SIG_W  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sync_in,
    input  logic                    sync_act_high,
    input  logic                    bit_mode,
    input  logic [NCH-1:0]          ch_valid,
    input  logic [NCH*BYTE_W-1:0]   ch_data,
    input  logic [NCH-1:0]          ch_fbit,
    input  logic [NCH*SIG_W-1:0]    ch_sig,
    output logic [NCH-1:0]          ch_ready,
    output logic                    ser_out,
    output logic [NCH-1:0]          underrun
);
    localparam int CH_W  = $clog2(NCH);
    localparam int BIT_W = $clog2(BYTE_W);
    localparam int RZ_N  = BYTE_W / 2;

    logic             sync_edge;
    phase_t           phase_w;
    logic [CH_W-1:0]  ch_w;
    logic [BIT_W-1:0] bit_w;
    logic             half_w, mode_w, slot_load_w, frame_load_w;
    logic [NCH-1:0]   lane_bits;

    tdm_sync_det u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_in   (sync_in),
        .act_high  (sync_act_high),
        .sync_edge (sync_edge)
    );

    tdm_seq #(
        .NCH    (NCH),
        .NSLOT  (NSLOT),
        .BYTE_W (BYTE_W),
        .SIG_W  (SIG_W)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .sync_edge    (sync_edge),
        .bit_mode_in  (bit_mode),
        .phase_o      (phase_w),
        .ch_o         (ch_w),
        .bit_o        (bit_w),
        .half_o       (half_w),
        .mode_o       (mode_w),
        .slot_load_o  (slot_load_w),
        .frame_load_o (frame_load_w)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_lane
        tdm_lane #(
            .BYTE_W (BYTE_W),
            .SIG_W  (SIG_W)
        ) u_lane (
            .clk        (clk),
            .rst_n      (rst_n),
            .slot_load  (slot_load_w),
            .frame_load (frame_load_w),
            .valid_i    (ch_valid[c]),
            .data_i     (ch_data[c*BYTE_W +: BYTE_W]),
            .fbit_i     (ch_fbit[c]),
            .sig_i      (ch_sig[c*SIG_W +: SIG_W]),
            .phase_i    (phase_w),
            .bit_i      (bit_w),
            .bit_o      (lane_bits[c]),
            .underrun_o (underrun[c])
        );
        assign ch_ready[c] = slot_load_w;
    end

    tdm_shaper #(
        .NCH    (NCH),
        .BYTE_W (BYTE_W)
    ) u_shaper (
        .clk       (clk),
        .rst_n     (rst_n),
        .lane_bits (lane_bits),
        .ch_i      (ch_w),
        .phase_i   (phase_w),
        .bit_i     (bit_w),
        .half_i    (half_w),
        .mode_i    (mode_w),
        .ser_o     (ser_out)
    );

    // R6: second clock of an early payload bit is low on the wire
    a_r6_rtz_low: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_w && phase_w == PH_PAY && half_w && bit_w < BIT_W'(RZ_N)) |=> !ser_out);
    // R7: ready strobes are a single clock wide
    a_r7_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ch_ready[0] |=> !ch_ready[0]);
endmodule

// File: tb/tdm_bitmux_out_tb.sv
module tdm_bitmux_out_tb;
    localparam int NCH   = 4;
    localparam int NSLOT = 24;
    localparam int BW    = 8;
    localparam int SW    = 4;
    localparam int FB    = NCH * (1 + NSLOT * BW + SW);   // bit periods per frame

    // row: [13] bit ordering, [12] sync active high, [11:8] underrun lanes, [7:0] seed
    localparam int NROW = 4;
    localparam logic [13:0] ROWS [NROW] = '{
        {1'b0, 1'b0, 4'b0000, 8'h3A},
        {1'b1, 1'b1, 4'b0100, 8'hC5},
        {1'b1, 1'b0, 4'b0000, 8'h5E},
        {1'b0, 1'b1, 4'b1001, 8'h81}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sync_in = 1'b1;
    logic sync_act_high = 1'b0;
    logic bit_mode = 1'b0;
    logic [NCH-1:0]    ch_valid = '0;
    logic [NCH*BW-1:0] ch_data = '0;
    logic [NCH-1:0]    ch_fbit = '0;
    logic [NCH*SW-1:0] ch_sig = '0;
    logic [NCH-1:0]    ch_ready;
    logic              ser_out;
    logic [NCH-1:0]    underrun;

    tdm_bitmux_out #(.NCH(NCH), .NSLOT(NSLOT), .BYTE_W(BW), .SIG_W(SW)) u_dut (
        .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .sync_act_high(sync_act_high),
        .bit_mode(bit_mode), .ch_valid(ch_valid), .ch_data(ch_data), .ch_fbit(ch_fbit),
        .ch_sig(ch_sig), .ch_ready(ch_ready), .ser_out(ser_out), .underrun(underrun)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_byte [NCH][NSLOT];
    int taken [NCH];
    int sl [NCH];
    bit pend [NCH];
    logic [NCH-1:0] umask = '0;
    logic [7:0] seed = '0;
    logic s_ser;
    logic [NCH-1:0] s_rdy;

    task automatic chk(input string tag, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // one clock: handshake model, capture of loads, sampling of outputs
    task automatic tick();
        @(negedge clk);
        for (int c = 0; c < NCH; c++) begin
            if (pend[c]) begin
                taken[c]++;
                pend[c] = 1'b0;
            end
            ch_data[c*BW +: BW] = 8'(taken[c] * 29 + c * 71 + int'(seed));
            ch_valid[c] = !(umask[c] && sl[c] == 2);
        end
        s_ser = ser_out;
        s_rdy = ch_ready;
        for (int c = 0; c < NCH; c++) begin
            if (ch_ready[c]) begin
                exp_byte[c][sl[c]] = ch_valid[c] ? ch_data[c*BW +: BW] : 8'hFF;   // R8 fill
                pend[c] = ch_valid[c];
                sl[c] = (sl[c] + 1) % NSLOT;
            end
        end
    endtask

    function automatic void classify(input int jj, input bit bm, output int cat, output logic b);
        int m, per, half, nf, np, r, s, q, k, c;
        m = bm ? 2 : 1;
        per = jj / m;
        half = jj % m;
        nf = NCH;
        np = NCH * NSLOT * BW;
        if (per < nf) begin
            cat = 0;
            b = ch_fbit[per];
        end else if (per < nf + np) begin
            r = per - nf;
            s = r / (NCH * BW);
            q = r % (NCH * BW);
            if (bm) begin k = q / NCH; c = q % NCH; end
            else    begin c = q / BW;  k = q % BW;  end
            b = exp_byte[c][s][BW-1-k];
            if (bm && k < BW / 2 && half == 1) begin
                b = 1'b0;
                cat = 2;
            end else begin
                cat = 1;
            end
        end else begin
            r = per - nf - np;
            if (bm) begin k = r / NCH; c = r % NCH; end
            else    begin c = r / SW;  k = r % SW;  end
            b = ch_sig[c*SW + SW - 1 - k];
            cat = 3;
        end
    endfunction

    task automatic start_sync(input bit pol);
        sync_in = pol;
        for (int c = 0; c < NCH; c++) sl[c] = 0;
        tick();
    endtask

    // walk one frame plus the next framing field and first slot
    task automatic run_frame(input bit bm, input bit pol, input bit flip);
        int m, fl, len, e_f, e_p, e_z, e_s, e_r, n_z, cat, t;
        logic b;
        logic [NCH-1:0] er;
        m = bm ? 2 : 1;
        fl = FB * m;
        len = fl + m * NCH * (1 + BW);
        e_f = 0; e_p = 0; e_z = 0; e_s = 0; e_r = 0; n_z = 0;
        for (int j = 0; j < len; j++) begin
            tick();
            if (j == 2) sync_in = ~pol;
            if (flip && j == 20) bit_mode = ~bm;    // R10 stimulus
            if (flip && j == 40) bit_mode = bm;
            classify(j % fl, bm, cat, b);
            if (s_ser !== b) begin
                if (cat == 0) e_f++;
                else if (cat == 1) e_p++;
                else if (cat == 2) e_z++;
                else e_s++;
            end
            if (cat == 2) n_z++;
            t = (j + 2) % fl - NCH * m;
            er = (t >= 0 && t % (NCH * BW * m) == 0 && t / (NCH * BW * m) < NSLOT) ? '1 : '0;
            if (s_rdy !== er) e_r++;
        end
        chk("R2/R3 framing bits after sync", e_f, 0);
        chk(bm ? "R5/R10 payload bit order" : "R4/R10 payload byte order", e_p, 0);
        chk(bm ? "R5 signaling bit order" : "R4 signaling order", e_s, 0);
        chk("R6 return-to-zero halves", e_z, 0);
        chk("R6 zero half count", n_z, bm ? (NSLOT + 1) * NCH * (BW / 2) : 0);
        chk("R7 ready timing", e_r, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [NCH-1:0] sticky;
        int idle_err;
        for (int c = 0; c < NCH; c++) begin
            taken[c] = 0; sl[c] = 0; pend[c] = 1'b0;
        end
        sticky = '0;
        repeat (4) tick();
        chk("R1 line mark in reset", int'(ser_out), 1);
        chk("R1 ready low in reset", int'(ch_ready), 0);
        chk("R1 underrun clear in reset", int'(underrun), 0);
        rst_n = 1'b1;
        idle_err = 0;
        for (int i = 0; i < 20; i++) begin
            tick();
            if (s_ser !== 1'b1 || s_rdy !== '0) idle_err++;
        end
        chk("R1 idle before sync", idle_err, 0);

        for (int ri = 0; ri < NROW; ri++) begin
            bit_mode      = ROWS[ri][13];
            sync_act_high = ROWS[ri][12];
            sync_in       = ~ROWS[ri][12];
            umask         = ROWS[ri][11:8];
            seed          = ROWS[ri][7:0];
            ch_fbit       = 4'hA ^ 4'(ri);
            ch_sig        = {seed, ~seed};
            tick();
            start_sync(ROWS[ri][12]);
            run_frame(ROWS[ri][13], ROWS[ri][12], 1'b1);
            sticky = sticky | ROWS[ri][11:8];
            chk("R8 sticky underrun flags", int'(underrun), int'(sticky));
        end

        // R9: restart in the middle of a frame
        start_sync(sync_act_high);
        tick();
        tick();
        sync_in = ~sync_act_high;
        repeat (300) tick();
        start_sync(sync_act_high);
        run_frame(bit_mode, sync_act_high, 1'b0);
        chk("R9 underrun kept over resync", int'(underrun), int'(sticky));

        rst_n = 1'b0;
        tick();
        tick();
        chk("R1/R8 reset clears underrun", int'(underrun), 0);
        chk("R1 line mark after reset", int'(ser_out), 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule